// File: doc/BRIEF.md
# Pin Edge Interrupt and Wake Unit

This block watches a bank of general-purpose input pins and turns their transitions into events. Each pin is brought into the clock domain through a synchronizer. Its current level is then compared with the level one clock earlier to find rising and falling transitions. Two independent pairs of per-pin enable masks decide what an edge does. The interrupt pair chooses which edges latch into a sticky pending register, and a single interrupt line reports that register. The wake pair, further gated by a per-pin sleep-control bit, chooses which edges raise a one-cycle wake request.

Software reaches the block through a simple synchronous register port. One write port selects a register by a 3-bit address, and one read port returns the addressed register one clock later. Pending events are cleared by writing ones to the pending address. A trigger command sets a single pin's interrupt edge enables, and it rejects any request for level sensitivity.

Top module: `gpio_edge_wake`

## Requirements
- R1: After a synchronous reset the four edge masks read 0, the sleep-control register reads all ones, the pending register reads 0, and `irq_o` and `wake_o` are low.
- R2: A 0-to-1 transition on a pin whose interrupt rising-enable bit (address 0) is set makes that pin's pending bit 1.
- R3: A 1-to-0 transition on a pin whose interrupt falling-enable bit (address 1) is set makes that pin's pending bit 1. A pin with both bits set latches both edges.
- R4: An edge whose interrupt enable for that direction is 0 leaves the pending register unchanged.
- R5: With the default two synchronizer stages, a pin change first sampled at clock edge k shows in the pending register and on `irq_o` after edge k+2, and not after edge k+1.
- R6: `irq_o` is high exactly when at least one pending bit is 1.
- R7: A write to address 5 clears every pending bit whose data bit is 1, and leaves every bit whose data bit is 0 as it was.
- R8: When a detected edge and a clear of the same pending bit fall in the same clock, the bit stays 1.
- R9: An edge enabled by the wake rising mask (address 2) or the wake falling mask (address 3) on a pin whose sleep bit (address 4) is 0 gives a `wake_o` pulse exactly one clock long, in the same cycle that a pending bit would appear. Wake masks never set pending bits.
- R10: A pin whose sleep bit is 1, or whose wake mask for that direction is 0, produces no wake pulse. Clearing the wake masks during reconfiguration therefore suppresses wake events.
- R11: A write to address 6 carries a pin index in bits [log2(W)-1:0] and a 4-bit trigger code above it (bit 0 rising, bit 1 falling, bit 2 level-high, bit 3 level-low). With neither level bit set, it loads that pin's interrupt rising and falling enables from bits 0 and 1. With any level bit set, the masks are unchanged.
- R12: Addresses 0 to 5 read back their registers on `rd_data_o` one clock after `rd_addr_i` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | W | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | W | Registered read data |
| irq_o | output | 1 | Combined interrupt, high while any event is pending |
| wake_o | output | 1 | One-cycle wake request |

## Verification
The bench uses an 8-pin configuration. It sweeps every pin through every combination of interrupt rising and falling enables, driving a single rising transition and then a single falling one. This separates the two edge detectors, shows that a disabled direction is ignored, and shows that pending bits accumulate. A second sweep covers every wake-mask combination against both sleep-bit values on every pin. Each step checks that the wake pulse lasts exactly one cycle and that pending stays empty, which separates the wake path from the interrupt path. Directed patterns then cover the first cycle in which an event becomes visible, partial clears, an edge that collides with a clear, and trigger commands with and without level bits.

// File: rtl/gpio_edge_wake_pkg.sv
package gpio_edge_wake_pkg;

  localparam int REG_AW = 3;
  localparam int TRIG_W = 4;

  typedef enum logic [REG_AW-1:0] {
    RS_RISE_IRQ  = 3'd0,
    RS_FALL_IRQ  = 3'd1,
    RS_RISE_WAKE = 3'd2,
    RS_FALL_WAKE = 3'd3,
    RS_SLEEP     = 3'd4,
    RS_PEND      = 3'd5,
    RS_TRIG      = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic fall;
    logic rise;
  } trig_code_t;

endpackage

// File: rtl/gew_sync.sv
module gew_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gew_edge.sv
module gew_edge #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/gew_pend.sv
module gew_pend #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);

  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic         irq_q;

  // a new event overrides a clear aimed at the same bit
  assign pend_d = (pend_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/gew_wake.sv
module gew_wake #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] sleep_i,
  output logic         wake_o
);

  logic [W-1:0] hit;
  logic         wake_q;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit[i] = ((rise_i[i] & rise_en_i[i]) | (fall_i[i] & fall_en_i[i])) & ~sleep_i[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) wake_q <= 1'b0;
    else       wake_q <= |hit;
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/gpio_edge_wake.sv
module gpio_edge_wake
  import gpio_edge_wake_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [W-1:0]      pin_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  output logic              irq_o,
  output logic              wake_o
);

  localparam int PIN_W = $clog2(W);
  localparam logic [PIN_W:0] PIN_LIMIT = W[PIN_W:0];

  // configuration registers
  logic [W-1:0] rise_irq_q;
  logic [W-1:0] fall_irq_q;
  logic [W-1:0] rise_wake_q;
  logic [W-1:0] fall_wake_q;
  logic [W-1:0] sleep_q;
  logic [W-1:0] rd_q;

  // datapath
  logic [W-1:0] lvl_sync;
  logic [W-1:0] rise_e;
  logic [W-1:0] fall_e;
  logic [W-1:0] evt_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] pend_q;

  // trigger command decode
  reg_sel_e         wr_sel;
  reg_sel_e         rd_sel;
  logic [PIN_W-1:0] trig_pin;
  trig_code_t       trig_code;
  logic             trig_ok;

  assign wr_sel    = reg_sel_e'(wr_addr_i);
  assign rd_sel    = reg_sel_e'(rd_addr_i);
  assign trig_pin  = wr_data_i[PIN_W-1:0];
  assign trig_code = trig_code_t'(wr_data_i[PIN_W +: TRIG_W]);
  assign trig_ok   = !trig_code.lvl_hi && !trig_code.lvl_lo && ({1'b0, trig_pin} < PIN_LIMIT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rise_irq_q  <= '0;
      fall_irq_q  <= '0;
      rise_wake_q <= '0;
      fall_wake_q <= '0;
      sleep_q     <= '1;
    end else if (wr_en_i) begin
      case (wr_sel)
        RS_RISE_IRQ:  rise_irq_q  <= wr_data_i;
        RS_FALL_IRQ:  fall_irq_q  <= wr_data_i;
        RS_RISE_WAKE: rise_wake_q <= wr_data_i;
        RS_FALL_WAKE: fall_wake_q <= wr_data_i;
        RS_SLEEP:     sleep_q     <= wr_data_i;
        RS_TRIG: begin
          if (trig_ok) begin
            rise_irq_q[trig_pin] <= trig_code.rise;
            fall_irq_q[trig_pin] <= trig_code.fall;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q <= '0;
    end else begin
      case (rd_sel)
        RS_RISE_IRQ:  rd_q <= rise_irq_q;
        RS_FALL_IRQ:  rd_q <= fall_irq_q;
        RS_RISE_WAKE: rd_q <= rise_wake_q;
        RS_FALL_WAKE: rd_q <= fall_wake_q;
        RS_SLEEP:     rd_q <= sleep_q;
        RS_PEND:      rd_q <= pend_q;
        default:      rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;

  gew_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_i),
    .q_o   (lvl_sync)
  );

  gew_edge #(.W(W)) edge_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (lvl_sync),
    .rise_o (rise_e),
    .fall_o (fall_e)
  );

  assign evt_vec = (rise_e & rise_irq_q) | (fall_e & fall_irq_q);
  assign clr_vec = (wr_en_i && wr_sel == RS_PEND) ? wr_data_i : '0;

  gew_pend #(.W(W)) pend_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (evt_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_q),
    .irq_o  (irq_o)
  );

  gew_wake #(.W(W)) wake_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rise_i    (rise_e),
    .fall_i    (fall_e),
    .rise_en_i (rise_wake_q),
    .fall_en_i (fall_wake_q),
    .sleep_i   (sleep_q),
    .wake_o    (wake_o)
  );

endmodule

// File: rtl/gew_checker.sv
module gew_checker
  import gpio_edge_wake_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              irq_o,
  input logic              wake_o,
  input logic [W-1:0]      pend_q,
  input logic [W-1:0]      evt_vec,
  input logic [W-1:0]      clr_vec,
  input logic [W-1:0]      sleep_q,
  input logic [W-1:0]      rise_irq_q,
  input logic [W-1:0]      fall_irq_q,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic [W-1:0]      wr_data_i
);

  localparam int PIN_W = $clog2(W);

  logic lvl_req;
  assign lvl_req = wr_en_i && (wr_addr_i == RS_TRIG) &&
                   (wr_data_i[PIN_W+2] || wr_data_i[PIN_W+3]);

  // R6
  irq_matches_pend_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == (pend_q != '0));

  // R7
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec) & ~$past(evt_vec)) == '0));

  // R8
  event_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_vec != '0) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

  // R4
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_vec == '0 && clr_vec == '0) |=> $stable(pend_q));

  // R10
  sleep_blocks_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (&sleep_q) |=> !wake_o);

  // R11
  level_reject_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    lvl_req |=> ($stable(rise_irq_q) && $stable(fall_irq_q)));

endmodule

bind gpio_edge_wake gew_checker #(.W(W)) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .pend_q     (pend_q),
  .evt_vec    (evt_vec),
  .clr_vec    (clr_vec),
  .sleep_q    (sleep_q),
  .rise_irq_q (rise_irq_q),
  .fall_irq_q (fall_irq_q),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i)
);

// File: tb/gpio_edge_wake_tb.sv
module gpio_edge_wake_tb_top;

  localparam int N  = 8;
  localparam int PW = 3;

  localparam logic [2:0] A_RI = 3'd0;
  localparam logic [2:0] A_FI = 3'd1;
  localparam logic [2:0] A_RW = 3'd2;
  localparam logic [2:0] A_FW = 3'd3;
  localparam logic [2:0] A_SL = 3'd4;
  localparam logic [2:0] A_PD = 3'd5;
  localparam logic [2:0] A_TG = 3'd6;

  logic         clk = 1'b0;
  logic         rst_i;
  logic [N-1:0] pins;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [N-1:0] wr_data;
  logic [2:0]   rd_addr;
  logic [N-1:0] rd_data;
  logic         irq_o;
  logic         wake_o;

  int n_chk = 0;
  int n_err = 0;

  always #10ns clk = ~clk;

  gpio_edge_wake #(.W(N)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst_i),
    .pin_i     (pins),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] exp_p;
    rst_i = 1'b1; pins = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);

    // R1 reset values
    check("R1 irq after reset", 32'(irq_o), 32'd0);
    check("R1 wake after reset", 32'(wake_o), 32'd0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 register reset value", 32'(v), (a == 4) ? 32'hFF : 32'd0);
    end

    // R12 readback
    for (int a = 0; a < 5; a++) begin
      wr(3'(a), 8'(8'h5A ^ a));
      rd(3'(a), v);
      check("R12 readback", 32'(v), 32'(8'h5A ^ a));
    end
    for (int a = 0; a < 4; a++) wr(3'(a), '0);
    wr(A_SL, '1);

    // R2 R3 R4 R6 sweep: every pin, every interrupt enable combination
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 4; c++) begin
        wr(A_RI, c[0] ? N'(1 << p) : '0);
        wr(A_FI, c[1] ? N'(1 << p) : '0);
        wr(A_PD, '1);
        pins[p] = 1'b1;
        settle();
        exp_p = c[0] ? N'(1 << p) : '0;
        check("R6 irq after rising edge", 32'(irq_o), 32'(exp_p != 0));
        rd(A_PD, v);
        check(c[0] ? "R2 rising edge pending" : "R4 disabled rising ignored", 32'(v), 32'(exp_p));
        pins[p] = 1'b0;
        settle();
        if (c[1]) exp_p = N'(1 << p);
        check("R6 irq after falling edge", 32'(irq_o), 32'(exp_p != 0));
        rd(A_PD, v);
        check(c[1] ? "R3 falling edge pending" : "R4 disabled falling ignored", 32'(v), 32'(exp_p));
      end
    end
    wr(A_RI, '0); wr(A_FI, '0); wr(A_PD, '1);

    // R9 R10 sweep: wake masks against sleep bit
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < 2; s++) begin
          wr(A_RW, c[0] ? N'(1 << p) : '0);
          wr(A_FW, c[1] ? N'(1 << p) : '0);
          wr(A_SL, s[0] ? '1 : N'(~(1 << p)));
          pins[p] = 1'b1;
          settle();
          check((c[0] && !s[0]) ? "R9 wake on rising" : "R10 wake blocked rising",
                32'(wake_o), 32'(c[0] && !s[0]));
          @(negedge clk);
          check("R9 wake pulse one cycle", 32'(wake_o), 32'd0);
          pins[p] = 1'b0;
          settle();
          check((c[1] && !s[0]) ? "R9 wake on falling" : "R10 wake blocked falling",
                32'(wake_o), 32'(c[1] && !s[0]));
          rd(A_PD, v);
          check("R9 wake leaves pending empty", 32'(v), 32'd0);
        end
      end
    end
    wr(A_RW, '0); wr(A_FW, '0); wr(A_SL, '1);

    // R5 latency
    wr(A_RI, 8'h04);
    pins[2] = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 not yet visible", 32'(irq_o), 32'd0);
    @(negedge clk);
    check("R5 visible after third edge", 32'(irq_o), 32'd1);
    pins[2] = 1'b0;
    wr(A_PD, '1);
    @(negedge clk);

    // R7 partial clear
    wr(A_RI, 8'h03);
    pins[1:0] = 2'b11;
    settle();
    rd(A_PD, v);
    check("R7 two pending", 32'(v), 32'h03);
    wr(A_PD, 8'h01);
    rd(A_PD, v);
    check("R7 zero bit kept", 32'(v), 32'h02);
    check("R6 irq with one pending", 32'(irq_o), 32'd1);
    wr(A_PD, 8'h02);
    rd(A_PD, v);
    check("R7 cleared", 32'(v), 32'h00);
    check("R6 irq low when empty", 32'(irq_o), 32'd0);
    pins[1:0] = 2'b00;
    settle();

    // R8 edge colliding with clear
    wr(A_RI, 8'h01); wr(A_FI, 8'h01);
    pins[0] = 1'b1;
    settle();
    pins[0] = 1'b0;
    repeat (2) @(negedge clk);
    wr(A_PD, 8'h01);
    rd(A_PD, v);
    check("R8 event wins over clear", 32'(v), 32'h01);
    wr(A_PD, 8'h01);
    rd(A_PD, v);
    check("R7 clear without event", 32'(v), 32'h00);

    // R11 trigger command
    wr(A_RI, '0); wr(A_FI, '0);
    wr(A_TG, N'((4'b0001 << PW) | 3));
    rd(A_RI, v); check("R11 rise only rise mask", 32'(v), 32'h08);
    rd(A_FI, v); check("R11 rise only fall mask", 32'(v), 32'h00);
    wr(A_TG, N'((4'b0011 << PW) | 5));
    rd(A_RI, v); check("R11 both rise mask", 32'(v), 32'h28);
    rd(A_FI, v); check("R11 both fall mask", 32'(v), 32'h20);
    wr(A_TG, N'((4'b0110 << PW) | 3));
    rd(A_RI, v); check("R11 level high rejected rise", 32'(v), 32'h28);
    rd(A_FI, v); check("R11 level high rejected fall", 32'(v), 32'h20);
    wr(A_TG, N'((4'b1000 << PW) | 5));
    rd(A_RI, v); check("R11 level low rejected rise", 32'(v), 32'h28);
    rd(A_FI, v); check("R11 level low rejected fall", 32'(v), 32'h20);
    wr(A_TG, N'((4'b0000 << PW) | 3));
    rd(A_RI, v); check("R11 disable pin rise", 32'(v), 32'h20);
    pins[5] = 1'b1;
    settle();
    rd(A_PD, v); check("R11 command mask drives pending", 32'(v), 32'h20);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule